// File: doc/BRIEF.md
# Interleaved I/Q Word De-interleaver

This block takes a single shared data bus that carries in-phase (I) and quadrature (Q) words one after another and turns it into two aligned sample streams, one per channel, ready for a pair of interpolation filters. Every bus word comes with a channel tag, and a write strobe marks the cycles that carry a word. Everything runs on one clock. In the most common use the strobe is held high all the time, so a new word arrives on every edge and one matched I/Q pair is produced every second cycle.

A small pairing state machine makes sure that the two words released together really belong together. An I word is held until a Q word follows it. Only then do both channel outputs update in the same cycle, with a one-cycle valid pulse. A word that arrives out of order throws away the incomplete pair, and pairing starts again.

A single active-high control pin does two jobs, depending on how long it stays high. A short pulse clears the pairing logic. If the pin stays high for a set number of cycles, a sleep flag rises and stays up until the pin drops. The pairing logic is also held clear for as long as the pin is high.

Top module: `iq_deinterleaver`

## Requirements
- R1: The data bus is `DATA_W` (10) bits wide with bit 9 the most significant bit, and it passes to the outputs unchanged. A tag value of 1 on `word_is_i` marks an I word and 0 marks a Q word.
- R2: When a Q word is accepted while an I word is pending, the clock edge that accepts it loads `i_data` with the pending I word and `q_data` with that Q word, and `pair_vld` is high in the cycle that follows.
- R3: `pair_vld` is never high for two cycles in a row. With the strobe held high and the tags alternating I, Q, it pulses on every second cycle.
- R4: A Q word that arrives with no I word pending is discarded. No pulse follows, and both outputs keep their values.
- R5: A second I word that arrives while an I word is pending replaces it, and the next Q word pairs with the newer I word.
- R6: When `wr_strobe` is low, the bus and tag are ignored: the pairing state and the outputs do not change.
- R7: Between pulses of `pair_vld`, `i_data` and `q_data` hold their last values.
- R8: While `rst_slp` is high, accepted words are ignored and any pending I word is dropped. After a pulse of one or more cycles, a lone Q word does not form a pair.
- R9: `sleep` rises in the cycle after the edge at which `rst_slp` has been sampled high on `SLEEP_CYC` (4) consecutive edges. Three consecutive high samples never raise it.
- R10: `sleep` clears at the first edge at which `rst_slp` is sampled low, and pairing then starts from the empty state.
- R11: After `rst_n` is released, `i_data` and `q_data` are zero and `pair_vld` and `sleep` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| wr_strobe | input | 1 | High when the bus carries a word to capture |
| word_is_i | input | 1 | Channel tag: 1 for I, 0 for Q |
| bus_word | input | DATA_W | Interleaved data word |
| rst_slp | input | 1 | Active-high control pin: short pulse clears pairing, long hold requests sleep |
| i_data | output | DATA_W | I sample of the last released pair |
| q_data | output | DATA_W | Q sample of the last released pair |
| pair_vld | output | 1 | One-cycle pulse marking a newly released pair |
| sleep | output | 1 | Power-down request flag |

## Verification
Every result comes one register after its cause. The pair outputs and the valid pulse show the effect of the edge that accepts the Q word. The sleep flag shows the effect of the edge that takes the fourth consecutive high sample of the control pin, and it drops at the edge that takes the first low sample. The bench changes inputs on the falling edge and reads outputs shortly after the next rising edge, so every check looks at the cycle in which that single register stage has just updated. An I/Q sweep then covers every 10-bit I code, each paired with a Q code computed arithmetically, and the ordering and control-pin cases are checked one step at a time.

// File: rtl/iq_deint_pkg.sv
package iq_deint_pkg;

  typedef enum logic [0:0] {
    PAIR_EMPTY = 1'b0,
    PAIR_HAVE_I = 1'b1
  } pair_state_e;

  // Next value of a hold counter that saturates at a limit.
  function automatic int unsigned hold_step(input int unsigned cur,
                                            input int unsigned lim,
                                            input logic pin);
    if (!pin) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

  // True when the current accepted word completes a pair.
  function automatic logic completes_pair(input pair_state_e st,
                                          input logic take,
                                          input logic is_i);
    return take && !is_i && (st == PAIR_HAVE_I);
  endfunction

endpackage

// File: rtl/iq_slp_monitor.sv
module iq_slp_monitor #(
  parameter int unsigned SLEEP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic clr_o,
  output logic sleep_o
);
  import iq_deint_pkg::*;

  localparam int unsigned CNT_W = $clog2(SLEEP_CYC + 1);

  logic [CNT_W-1:0] hold_cnt;
  logic [CNT_W-1:0] hold_nxt;
  logic             reach_lim;

  always_comb begin
    hold_nxt  = CNT_W'(hold_step(int'(hold_cnt), SLEEP_CYC, pin));
    reach_lim = pin && (int'(hold_nxt) >= int'(SLEEP_CYC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      sleep_o  <= 1'b0;
    end else begin
      hold_cnt <= hold_nxt;
      sleep_o  <= reach_lim;
    end
  end

  // Pairing is held clear for as long as the pin is high.
  assign clr_o = pin;

endmodule

// File: rtl/iq_pair_fsm.sv
module iq_pair_fsm #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic              is_i,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] i_o,
  output logic [DATA_W-1:0] q_o,
  output logic              vld_o
);
  import iq_deint_pkg::*;

  pair_state_e      state;
  pair_state_e      state_nxt;
  logic [DATA_W-1:0] i_hold;
  logic             take;
  logic             done;

  always_comb begin
    take      = wr && !clr;
    done      = completes_pair(state, take, is_i);
    state_nxt = state;
    if (clr) begin
      state_nxt = PAIR_EMPTY;
    end else if (take) begin
      state_nxt = is_i ? PAIR_HAVE_I : PAIR_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PAIR_EMPTY;
      i_hold <= '0;
      i_o    <= '0;
      q_o    <= '0;
      vld_o  <= 1'b0;
    end else begin
      state <= state_nxt;
      vld_o <= done;
      if (take && is_i) i_hold <= word;
      if (done) begin
        i_o <= i_hold;
        q_o <= word;
      end
    end
  end

endmodule

// File: rtl/iq_deinterleaver.sv
module iq_deinterleaver #(
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned SLEEP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic              word_is_i,
  input  logic [DATA_W-1:0] bus_word,
  input  logic              rst_slp,
  output logic [DATA_W-1:0] i_data,
  output logic [DATA_W-1:0] q_data,
  output logic              pair_vld,
  output logic              sleep
);

  logic pair_clr;

  iq_slp_monitor #(.SLEEP_CYC(SLEEP_CYC)) u_slp (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (rst_slp),
    .clr_o  (pair_clr),
    .sleep_o(sleep)
  );

  iq_pair_fsm #(.DATA_W(DATA_W)) u_pair (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pair_clr),
    .wr   (wr_strobe),
    .is_i (word_is_i),
    .word (bus_word),
    .i_o  (i_data),
    .q_o  (q_data),
    .vld_o(pair_vld)
  );

endmodule

// File: rtl/iq_deint_checker.sv
module iq_deint_checker #(
  parameter int unsigned DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_strobe,
  input logic              word_is_i,
  input logic [DATA_W-1:0] bus_word,
  input logic              rst_slp,
  input logic [DATA_W-1:0] i_data,
  input logic [DATA_W-1:0] q_data,
  input logic              pair_vld,
  input logic              sleep
);

  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |=> !pair_vld); // R3

  AST_VLD_FROM_Q: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |-> ($past(wr_strobe) && !$past(word_is_i) && (q_data == $past(bus_word)))); // R2

  AST_NO_PAIR_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_slp |=> !pair_vld); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_vld |-> ($stable(i_data) && $stable(q_data))); // R7

  AST_SLEEP_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> $past(rst_slp)); // R9

  AST_SLEEP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_slp |=> !sleep); // R10

  AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> !pair_vld); // R6

endmodule

bind iq_deinterleaver iq_deint_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_strobe(wr_strobe),
  .word_is_i(word_is_i),
  .bus_word (bus_word),
  .rst_slp  (rst_slp),
  .i_data   (i_data),
  .q_data   (q_data),
  .pair_vld (pair_vld),
  .sleep    (sleep)
);

// File: tb/iq_deinterleaver_tb_top.sv
`timescale 1ns/1ps
module iq_deinterleaver_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_strobe = 1'b0;
  logic          word_is_i = 1'b0;
  logic [DW-1:0] bus_word = '0;
  logic          rst_slp = 1'b0;
  logic [DW-1:0] i_data;
  logic [DW-1:0] q_data;
  logic          pair_vld;
  logic          sleep;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_deinterleaver dut_i (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .word_is_i(word_is_i),
    .bus_word(bus_word), .rst_slp(rst_slp), .i_data(i_data), .q_data(q_data),
    .pair_vld(pair_vld), .sleep(sleep)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive on the falling edge, sample just after the next rising edge.
  task automatic step(input logic wr, input logic is_i, input int w, input logic pin);
    @(negedge clk);
    wr_strobe = wr;
    word_is_i = is_i;
    bus_word  = DW'(w);
    rst_slp   = pin;
    @(posedge clk);
    #1;
  endtask

  function automatic int q_of(input int i);
    return (i * 37 + 501) % 1024;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 i_data", int'(i_data), 0);
    check("R11 q_data", int'(q_data), 0);
    check("R11 pair_vld", int'(pair_vld), 0);
    check("R11 sleep", int'(sleep), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3: sweep of every I code, paired with a computed Q code
    for (int i = 0; i < 1024; i++) begin
      step(1'b1, 1'b1, i, 1'b0);
      check("R3 no pulse after I", int'(pair_vld), 0);
      step(1'b1, 1'b0, q_of(i), 1'b0);
      check("R2 pulse after Q", int'(pair_vld), 1);
      check("R1 i_data", int'(i_data), i);
      check("R1 q_data", int'(q_data), q_of(i));
    end

    // R7: outputs hold after the pulse
    step(1'b0, 1'b0, 5, 1'b0);
    check("R7 pulse low", int'(pair_vld), 0);
    check("R7 i hold", int'(i_data), 1023);
    check("R7 q hold", int'(q_data), q_of(1023));

    // R4: lone Q discarded
    step(1'b1, 1'b0, 77, 1'b0);
    check("R4 no pulse", int'(pair_vld), 0);
    check("R4 q unchanged", int'(q_data), q_of(1023));

    // R5: second I replaces the first
    step(1'b1, 1'b1, 100, 1'b0);
    step(1'b1, 1'b1, 200, 1'b0);
    check("R5 no pulse on I", int'(pair_vld), 0);
    step(1'b1, 1'b0, 300, 1'b0);
    check("R5 pulse", int'(pair_vld), 1);
    check("R5 newest I", int'(i_data), 200);
    check("R5 q", int'(q_data), 300);

    // R6: strobe low ignores the bus
    step(1'b1, 1'b1, 11, 1'b0);
    step(1'b0, 1'b0, 22, 1'b0);
    check("R6 no pulse", int'(pair_vld), 0);
    check("R6 q unchanged", int'(q_data), 300);
    step(1'b1, 1'b0, 33, 1'b0);
    check("R6 pending kept", int'(pair_vld), 1);
    check("R6 i", int'(i_data), 11);
    check("R6 q", int'(q_data), 33);

    // R8: short pulse drops pending I
    step(1'b1, 1'b1, 44, 1'b0);
    step(1'b1, 1'b0, 55, 1'b1);
    check("R8 no pulse in clear", int'(pair_vld), 0);
    check("R8 sleep low on short", int'(sleep), 0);
    step(1'b1, 1'b0, 66, 1'b0);
    check("R8 lone Q after pulse", int'(pair_vld), 0);
    check("R8 q unchanged", int'(q_data), 33);

    // R9: hold the pin; three samples are not enough, four are
    step(1'b1, 1'b1, 1, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      step(1'b1, (k % 2) == 0, k, 1'b1);
      check("R9 sleep", int'(sleep), (k >= 4) ? 1 : 0);
      check("R8 no pulse while held", int'(pair_vld), 0);
    end

    // R10: falling pin clears sleep and restarts pairing
    step(1'b1, 1'b0, 90, 1'b0);
    check("R10 sleep cleared", int'(sleep), 0);
    check("R10 no stale pair", int'(pair_vld), 0);
    step(1'b1, 1'b1, 91, 1'b0);
    step(1'b1, 1'b0, 92, 1'b0);
    check("R10 pairing resumes", int'(pair_vld), 1);
    check("R10 i", int'(i_data), 91);
    check("R10 q", int'(q_data), 92);

    // R9: exactly three samples high, then low
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b0, 0, 1'b1);
      check("R9 three samples", int'(sleep), 0);
    end
    step(1'b0, 1'b0, 0, 1'b0);
    check("R9 still low", int'(sleep), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule